// File: doc/BRIEF.md
# Write-Allocate Data Cache with Streaming Line Fill

This block is a small write-back, write-allocate data cache. It sits between a 32-bit word load/store port and a next-level memory that transfers whole 32-byte lines (eight words, 256 bits). The cache is direct-mapped with `LINES` entries. Each entry has a valid bit, a dirty bit and a tag.

A store that misses the cache does not fetch the line right away. It opens a single-line gather buffer instead. Later stores to that same line add words to the buffer. If all eight words get written, the line is installed from the gathered data and nothing is read from the next level. If the run ends early, the line is refilled from the next level and the gathered words are merged over the refill. The miss counter counts only refills from the next level, so a long fill loop that streams whole lines adds almost nothing to it.

The same port also takes per-line maintenance commands: clean, invalidate, and clean-and-invalidate. The requester holds a request until `ready_o` rises. The next-level port uses a valid/ready handshake.

Top module: `wa_stream_cache`

## Requirements
- R1: After reset every line is invalid, the gather buffer is empty, `miss_cnt_o` is 0, `mem_req_o` is low, and `ready_o` is low while `req_i` is low.
- R2: A load (`op_i`=0) that misses does one next-level line read (`mem_we_o`=0) at the line-aligned address and adds 1 to the miss counter. It then returns the addressed word: word w of a line is bits [32w+31:32w], with w = addr[4:2], index = addr[8:5] and tag = addr[31:9] for the defaults. A second load to that line makes no next-level access.
- R3: A store (`op_i`=1) that hits updates only the cached word and marks the line dirty. No next-level access happens, and later loads return the new value.
- R4: Stores that write all eight words of one missing line, in any order and with no other access in between, install that line with no next-level read and no change to the miss counter. The counter changes only when a refill completes or on a clear.
- R5: If a gather run ends before the line is full, the run is closed by one next-level read. The gathered words are merged over the refill, the miss counter adds 1, and the line becomes dirty. A run ends with a store to another line, a load of a word not in the buffer, or any maintenance command. Later stores to that line are hits.
- R6: Before a line is installed, by refill or by full gather, a dirty line held at that index with a different tag is written to its own line address with its full cached contents. A next-level write is only ever made for a valid, dirty line.
- R7: Clean (`op_i`=2) on a dirty hit writes the line back and keeps it valid and now clean, so a later load makes no next-level access. Clean on a clean line or on a miss makes no next-level access.
- R8: Invalidate (`op_i`=3) drops a hit line with no write-back, so unwritten store data is lost and the next load refills.
- R9: Clean-and-invalidate (`op_i`=4) writes back a dirty hit line and then drops it. A later load refills and sees the written data.
- R10: A load of a word already held in the gather buffer returns the buffered value with no next-level access, and the gather run stays open.
- R11: The miss counter is `CNT_W` bits wide (32 by default). It saturates at all ones, and `miss_clr_i` sets it to 0 on the next clock.
- R12: `mem_req_o`, `mem_we_o`, `mem_addr_o` and, for writes, `mem_wdata_o` stay stable until a cycle with `mem_ready_i` high. `ready_o` is low whenever `mem_req_o` is high.

Note on R1: since `ready_o` is low while `req_i` is low, after reset the only output values that can be seen directly are `mem_req_o`, `ready_o` and `miss_cnt_o`. The "every line invalid" and "buffer empty" parts are shown by the first load missing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, held until `ready_o` |
| op_i | input | 3 | 0 load, 1 store, 2 clean, 3 invalidate, 4 clean-and-invalidate |
| addr_i | input | ADDR_W | Byte address (word-aligned) |
| wdata_i | input | 32 | Store data |
| ready_o | output | 1 | Access completes at this clock edge |
| rdata_o | output | 32 | Load data, valid while `ready_o` is high |
| mem_req_o | output | 1 | Next-level request valid |
| mem_we_o | output | 1 | 1 line write, 0 line read |
| mem_addr_o | output | ADDR_W | Line-aligned byte address |
| mem_wdata_o | output | 256 | Line write data |
| mem_ready_i | input | 1 | Next level accepts or completes the transfer |
| mem_rdata_i | input | 256 | Line read data, valid with `mem_ready_i` |
| miss_clr_i | input | 1 | Synchronous clear of the miss counter |
| miss_cnt_o | output | CNT_W | Refill count, saturating |

## Verification
The assertions assume three things about the inputs:
- The requester keeps `req_i`, `op_i`, `addr_i` and `wdata_i` fixed until the access completes.
- Addresses are word-aligned.
- `mem_ready_i` is raised only while `mem_req_o` is high, and it comes with the read data.

The stimulus keeps to these assumptions in two ways. The access task drives the inputs once and releases them only after the completing edge. The memory responder waits a fixed latency after it sees a request before it raises ready for one cycle.

// File: rtl/wsc_pkg.sv
`timescale 1ns/1ps
package wsc_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned LINE_W  = 256;
  localparam int unsigned NWORDS  = LINE_W / WORD_W;
  localparam int unsigned WSEL_W  = $clog2(NWORDS);
  localparam int unsigned OFF_W   = WSEL_W + 2;

  typedef enum logic [2:0] {
    OP_LOAD  = 3'd0,
    OP_STORE = 3'd1,
    OP_CLEAN = 3'd2,
    OP_INVAL = 3'd3,
    OP_CLINV = 3'd4
  } op_e;

  typedef enum logic [1:0] {ST_IDLE, ST_WB, ST_RF} st_e;
endpackage

// File: rtl/wsc_line_store.sv
`timescale 1ns/1ps
module wsc_line_store #(
  parameter int unsigned LINES  = 16,
  parameter int unsigned TAG_W  = 23,
  parameter int unsigned LINE_W = 256,
  parameter int unsigned WORD_W = 32,
  localparam int unsigned IDX_W  = $clog2(LINES),
  localparam int unsigned WSEL_W = $clog2(LINE_W / WORD_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic              valid_o,
  output logic              dirty_o,
  output logic [TAG_W-1:0]  tag_o,
  output logic [LINE_W-1:0] data_o,
  input  logic              fill_en_i,
  input  logic [IDX_W-1:0]  fill_idx_i,
  input  logic [TAG_W-1:0]  fill_tag_i,
  input  logic [LINE_W-1:0] fill_data_i,
  input  logic              fill_dirty_i,
  input  logic              word_en_i,
  input  logic [IDX_W-1:0]  word_idx_i,
  input  logic [WSEL_W-1:0] word_sel_i,
  input  logic [WORD_W-1:0] word_data_i,
  input  logic              clean_en_i,
  input  logic [IDX_W-1:0]  clean_idx_i,
  input  logic              inval_en_i,
  input  logic [IDX_W-1:0]  inval_idx_i
);
  logic [LINES-1:0]  valid_q, dirty_q;
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [LINE_W-1:0] data_q [LINES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else begin
      if (fill_en_i) begin
        valid_q[fill_idx_i] <= 1'b1;
        dirty_q[fill_idx_i] <= fill_dirty_i;
      end
      if (word_en_i)  dirty_q[word_idx_i]  <= 1'b1;
      if (clean_en_i) dirty_q[clean_idx_i] <= 1'b0;
      if (inval_en_i) valid_q[inval_idx_i] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i) begin
    if (fill_en_i) begin
      tag_q[fill_idx_i]  <= fill_tag_i;
      data_q[fill_idx_i] <= fill_data_i;
    end
    if (word_en_i) data_q[word_idx_i][word_sel_i*WORD_W +: WORD_W] <= word_data_i;
  end

  assign valid_o = valid_q[rd_idx_i];
  assign dirty_o = dirty_q[rd_idx_i];
  assign tag_o   = tag_q[rd_idx_i];
  assign data_o  = data_q[rd_idx_i];
endmodule

// File: rtl/wsc_gather.sv
`timescale 1ns/1ps
module wsc_gather #(
  parameter int unsigned LADDR_W = 27,
  parameter int unsigned LINE_W  = 256,
  parameter int unsigned WORD_W  = 32,
  localparam int unsigned NW     = LINE_W / WORD_W,
  localparam int unsigned WSEL_W = $clog2(NW)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic               wr_new_i,
  input  logic [LADDR_W-1:0] wr_line_i,
  input  logic [WSEL_W-1:0]  wr_sel_i,
  input  logic [WORD_W-1:0]  wr_data_i,
  input  logic               clr_i,
  output logic               valid_o,
  output logic [LADDR_W-1:0] line_o,
  output logic [NW-1:0]      mask_o,
  output logic [LINE_W-1:0]  data_o,
  output logic               full_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      line_o  <= '0;
      mask_o  <= '0;
    end else if (clr_i) begin
      valid_o <= 1'b0;
      mask_o  <= '0;
    end else if (wr_en_i) begin
      valid_o <= 1'b1;
      if (wr_new_i) begin
        line_o <= wr_line_i;
        mask_o <= NW'(1) << wr_sel_i;
      end else begin
        mask_o <= mask_o | (NW'(1) << wr_sel_i);
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) data_o[wr_sel_i*WORD_W +: WORD_W] <= wr_data_i;
  end

  assign full_o = &mask_o;

  // R4: a run only accumulates words until it is closed
  a_r4_mask_grows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !clr_i && !(wr_en_i && wr_new_i)) |=> ((mask_o & $past(mask_o)) == $past(mask_o)));
endmodule

// File: rtl/wsc_miss_ctr.sv
`timescale 1ns/1ps
module wsc_miss_ctr #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_o <= '0;
    else if (clr_i)                cnt_o <= '0;
    else if (inc_i && cnt_o != '1) cnt_o <= cnt_o + 1'b1;
  end

  a_r11_saturate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o == '1 && !clr_i) |=> (cnt_o == '1));
  a_r11_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_o == '0));
endmodule

// File: rtl/wa_stream_cache.sv
`timescale 1ns/1ps
module wa_stream_cache
  import wsc_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LINES  = 16,
  parameter int unsigned CNT_W  = 32,
  localparam int unsigned IDX_W   = $clog2(LINES),
  localparam int unsigned LADDR_W = ADDR_W - OFF_W,
  localparam int unsigned TAG_W   = LADDR_W - IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [2:0]        op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic              ready_o,
  output logic [WORD_W-1:0] rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [LINE_W-1:0] mem_wdata_o,
  input  logic              mem_ready_i,
  input  logic [LINE_W-1:0] mem_rdata_i,
  input  logic              miss_clr_i,
  output logic [CNT_W-1:0]  miss_cnt_o
);
  st_e st_q, st_d;
  logic [LADDR_W-1:0] wb_line_q, wb_line_d, rf_line_q, rf_line_d;

  op_e op;
  assign op = op_e'(op_i);
  logic [LADDR_W-1:0] cur_line, tgt_line;
  logic [WSEL_W-1:0]  cur_sel;
  assign cur_line = addr_i[ADDR_W-1:OFF_W];
  assign cur_sel  = addr_i[OFF_W-1:2];
  logic unused_lsb;
  assign unused_lsb = ^addr_i[1:0];

  // gather buffer
  logic               gb_wr, gb_new, gb_clr, gb_valid, gb_full;
  logic [LADDR_W-1:0] gb_line;
  logic [NWORDS-1:0]  gb_mask;
  logic [LINE_W-1:0]  gb_data;

  wsc_gather #(.LADDR_W(LADDR_W), .LINE_W(LINE_W), .WORD_W(WORD_W)) u_gather (
    .clk_i, .rst_ni,
    .wr_en_i(gb_wr), .wr_new_i(gb_new), .wr_line_i(cur_line), .wr_sel_i(cur_sel),
    .wr_data_i(wdata_i), .clr_i(gb_clr),
    .valid_o(gb_valid), .line_o(gb_line), .mask_o(gb_mask), .data_o(gb_data), .full_o(gb_full)
  );

  logic gb_match, gb_keep, flush_need;
  assign gb_match   = gb_valid && (gb_line == cur_line);
  assign gb_keep    = req_i && gb_match && (op == OP_STORE || (op == OP_LOAD && gb_mask[cur_sel]));
  assign flush_need = gb_valid && (gb_full || (req_i && !gb_keep));
  assign tgt_line   = flush_need ? gb_line : cur_line;

  logic [IDX_W-1:0] tgt_idx, rd_idx;
  logic [TAG_W-1:0] tgt_tag;
  assign tgt_idx = tgt_line[IDX_W-1:0];
  assign tgt_tag = tgt_line[LADDR_W-1:IDX_W];
  assign rd_idx  = (st_q == ST_WB) ? wb_line_q[IDX_W-1:0] : tgt_idx;

  // tag/state/data storage
  logic              ls_valid, ls_dirty;
  logic [TAG_W-1:0]  ls_tag;
  logic [LINE_W-1:0] ls_data, fill_data, merged;
  logic              fill_en, fill_dirty, word_en, clean_en, inval_en, gb_merge, miss_inc;
  logic [IDX_W-1:0]  fill_idx;
  logic [TAG_W-1:0]  fill_tag;

  wsc_line_store #(.LINES(LINES), .TAG_W(TAG_W), .LINE_W(LINE_W), .WORD_W(WORD_W)) u_store (
    .clk_i, .rst_ni, .rd_idx_i(rd_idx),
    .valid_o(ls_valid), .dirty_o(ls_dirty), .tag_o(ls_tag), .data_o(ls_data),
    .fill_en_i(fill_en), .fill_idx_i(fill_idx), .fill_tag_i(fill_tag),
    .fill_data_i(fill_data), .fill_dirty_i(fill_dirty),
    .word_en_i(word_en), .word_idx_i(tgt_idx), .word_sel_i(cur_sel), .word_data_i(wdata_i),
    .clean_en_i(clean_en), .clean_idx_i(wb_line_q[IDX_W-1:0]),
    .inval_en_i(inval_en), .inval_idx_i(tgt_idx)
  );

  logic hit, victim_dirty;
  assign hit          = ls_valid && (ls_tag == tgt_tag);
  assign victim_dirty = ls_valid && ls_dirty && !hit;

  // refill data with any gathered words laid over it
  assign gb_merge = gb_valid && (gb_line == rf_line_q);
  always_comb begin
    for (int w = 0; w < NWORDS; w++)
      merged[w*WORD_W +: WORD_W] = (gb_merge && gb_mask[w]) ? gb_data[w*WORD_W +: WORD_W]
                                                            : mem_rdata_i[w*WORD_W +: WORD_W];
  end

  assign fill_data  = (st_q == ST_RF) ? merged : gb_data;
  assign fill_idx   = (st_q == ST_RF) ? rf_line_q[IDX_W-1:0] : tgt_idx;
  assign fill_tag   = (st_q == ST_RF) ? rf_line_q[LADDR_W-1:IDX_W] : tgt_tag;
  assign fill_dirty = (st_q == ST_RF) ? gb_merge : 1'b1;

  assign mem_addr_o  = {((st_q == ST_RF) ? rf_line_q : wb_line_q), {OFF_W{1'b0}}};
  assign mem_wdata_o = ls_data;

  always_comb begin
    st_d = st_q; wb_line_d = wb_line_q; rf_line_d = rf_line_q;
    ready_o = 1'b0; rdata_o = ls_data[cur_sel*WORD_W +: WORD_W];
    mem_req_o = 1'b0; mem_we_o = 1'b0;
    fill_en = 1'b0; word_en = 1'b0; clean_en = 1'b0; inval_en = 1'b0;
    gb_wr = 1'b0; gb_new = 1'b0; gb_clr = 1'b0; miss_inc = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (flush_need) begin
          if (victim_dirty) begin
            wb_line_d = {ls_tag, tgt_idx}; st_d = ST_WB;
          end else if (gb_full) begin
            fill_en = 1'b1; gb_clr = 1'b1;       // whole line gathered: no refill
          end else begin
            rf_line_d = gb_line; st_d = ST_RF;
          end
        end else if (req_i) begin
          unique case (op)
            OP_LOAD: begin
              if (gb_keep) begin
                ready_o = 1'b1; rdata_o = gb_data[cur_sel*WORD_W +: WORD_W];
              end else if (hit) ready_o = 1'b1;
              else if (victim_dirty) begin
                wb_line_d = {ls_tag, tgt_idx}; st_d = ST_WB;
              end else begin
                rf_line_d = cur_line; st_d = ST_RF;
              end
            end
            OP_STORE: begin
              ready_o = 1'b1;
              if (gb_match) gb_wr = 1'b1;
              else if (hit) word_en = 1'b1;
              else begin gb_wr = 1'b1; gb_new = 1'b1; end
            end
            OP_CLEAN, OP_CLINV: begin
              if (hit && ls_dirty) begin
                wb_line_d = {ls_tag, tgt_idx}; st_d = ST_WB;
              end else begin
                inval_en = hit && (op == OP_CLINV); ready_o = 1'b1;
              end
            end
            OP_INVAL: begin inval_en = hit; ready_o = 1'b1; end
            default: ready_o = 1'b1;
          endcase
        end
      end
      ST_WB: begin
        mem_req_o = 1'b1; mem_we_o = 1'b1;
        if (mem_ready_i) begin clean_en = 1'b1; st_d = ST_IDLE; end
      end
      ST_RF: begin
        mem_req_o = 1'b1;
        if (mem_ready_i) begin
          fill_en = 1'b1; gb_clr = gb_merge; miss_inc = 1'b1; st_d = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; wb_line_q <= '0; rf_line_q <= '0;
    end else begin
      st_q <= st_d; wb_line_q <= wb_line_d; rf_line_q <= rf_line_d;
    end
  end

  wsc_miss_ctr #(.CNT_W(CNT_W)) u_miss (
    .clk_i, .rst_ni, .clr_i(miss_clr_i), .inc_i(miss_inc), .cnt_o(miss_cnt_o)
  );

  a_r12_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));
  a_r12_wdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o && !mem_ready_i) |=> $stable(mem_wdata_o));
  a_r12_busy_not_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !ready_o);
  a_r6_wb_only_dirty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> (ls_valid && ls_dirty));
  a_r4_count_refill_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!miss_clr_i && !(mem_req_o && !mem_we_o && mem_ready_i)) |=> $stable(miss_cnt_o));
endmodule

// File: tb/wa_stream_cache_tb_top.sv
`timescale 1ns/1ps
module wa_stream_cache_tb_top;
  localparam int CNT_W = 3;
  localparam int MAXC  = (1 << CNT_W) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic         req = 1'b0, mem_ready = 1'b0, miss_clr = 1'b0;
  logic [2:0]   op = '0;
  logic [31:0]  addr = '0, wdata = '0, rdata, mem_addr;
  logic [255:0] mem_wdata, mem_rdata = '0;
  logic         ready, mem_req, mem_we;
  logic [CNT_W-1:0] miss_cnt;

  wa_stream_cache #(.CNT_W(CNT_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .op_i(op), .addr_i(addr), .wdata_i(wdata),
    .ready_o(ready), .rdata_o(rdata), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_ready_i(mem_ready),
    .mem_rdata_i(mem_rdata), .miss_clr_i(miss_clr), .miss_cnt_o(miss_cnt)
  );

  int n_tests = 0, n_fail = 0;
  int rd_cnt = 0, wr_cnt = 0;

  task automatic chk(input bit ok, input string req_s, input string what,
                     input logic [255:0] act, input logic [255:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req_s, what, act, exp);
    end
  endtask

  // ---------------- next-level memory ----------------
  logic [255:0] nl_mem [int];

  function automatic logic [255:0] init_line(int la);
    logic [255:0] l;
    for (int w = 0; w < 8; w++) l[w*32 +: 32] = 32'hA500_0000 ^ (la << 3) ^ w;
    return l;
  endfunction

  function automatic logic [255:0] nl_get(int la);
    return nl_mem.exists(la) ? nl_mem[la] : init_line(la);
  endfunction

  int lat = 0;
  logic [31:0] la_q;
  logic lw_q, hold_bad = 1'b0, busy_bad = 1'b0;
  always @(negedge clk) begin
    if (mem_ready) begin
      mem_ready = 1'b0; lat = 0; hold_bad = 1'b0; busy_bad = 1'b0;
    end else if (mem_req) begin
      if (lat > 0 && (mem_addr != la_q || mem_we != lw_q)) hold_bad = 1'b1;
      if (ready) busy_bad = 1'b1;
      la_q = mem_addr; lw_q = mem_we; lat++;
      if (lat == 2) begin
        chk(!hold_bad, "R12", "request held stable", {255'd0, hold_bad}, 256'd0);
        chk(!busy_bad, "R12", "ready low while busy", {255'd0, busy_bad}, 256'd0);
        chk(mem_addr[4:0] == 5'd0, "R2", "line-aligned address", mem_addr, {mem_addr[31:5], 5'd0});
        if (mem_we) begin nl_mem[int'(mem_addr >> 5)] = mem_wdata; wr_cnt++; end
        else begin mem_rdata = nl_get(int'(mem_addr >> 5)); rd_cnt++; end
        mem_ready = 1'b1;
      end
    end
  end

  // ---------------- behavioural reference model ----------------
  bit           m_valid [16], m_dirty [16];
  int           m_tag   [16];
  logic [255:0] m_data  [16];
  logic [255:0] exp_mem [int];
  bit           g_valid = 0;
  int           g_line;
  logic [7:0]   g_mask = '0;
  logic [255:0] g_data;
  int           m_miss = 0;

  function automatic logic [255:0] e_get(int la);
    return exp_mem.exists(la) ? exp_mem[la] : init_line(la);
  endfunction

  function automatic void m_count_miss();
    if (m_miss < MAXC) m_miss++;
  endfunction

  function automatic void m_evict(int idx, int tg, inout int wr);
    if (m_valid[idx] && m_dirty[idx] && m_tag[idx] != tg) begin
      exp_mem[m_tag[idx] * 16 + idx] = m_data[idx]; wr++;
    end
  endfunction

  function automatic void m_flush(inout int rd, inout int wr);
    int idx = g_line % 16, tg = g_line / 16;
    logic [255:0] l;
    m_evict(idx, tg, wr);
    if (g_mask == 8'hFF) l = g_data;
    else begin
      l = e_get(g_line);
      for (int w = 0; w < 8; w++) if (g_mask[w]) l[w*32 +: 32] = g_data[w*32 +: 32];
      rd++; m_count_miss();
    end
    m_valid[idx] = 1; m_dirty[idx] = 1; m_tag[idx] = tg; m_data[idx] = l;
    g_valid = 0; g_mask = '0;
  endfunction

  function automatic void m_access(input int o, input logic [31:0] a, input logic [31:0] d,
                                   output logic [31:0] rv, output int rd, output int wr);
    int la = int'(a >> 5), sel = int'(a[4:2]), idx = la % 16, tg = la / 16;
    bit h;
    rd = 0; wr = 0; rv = '0;
    if (o == 0 && g_valid && g_line == la && g_mask[sel]) begin
      rv = g_data[sel*32 +: 32]; return;
    end
    if (o == 1 && g_valid && g_line == la) begin
      g_data[sel*32 +: 32] = d; g_mask[sel] = 1'b1;
      if (g_mask == 8'hFF) m_flush(rd, wr);
      return;
    end
    if (g_valid) m_flush(rd, wr);
    h = m_valid[idx] && m_tag[idx] == tg;
    case (o)
      0: begin
        if (!h) begin
          m_evict(idx, tg, wr); rd++; m_count_miss();
          m_valid[idx] = 1; m_dirty[idx] = 0; m_tag[idx] = tg; m_data[idx] = e_get(la);
        end
        rv = m_data[idx][sel*32 +: 32];
      end
      1: begin
        if (h) begin m_data[idx][sel*32 +: 32] = d; m_dirty[idx] = 1; end
        else begin g_valid = 1; g_line = la; g_mask = 8'd1 << sel; g_data[sel*32 +: 32] = d; end
      end
      default: begin
        if ((o == 2 || o == 4) && h && m_dirty[idx]) begin
          exp_mem[la] = m_data[idx]; wr++; m_dirty[idx] = 0;
        end
        if ((o == 3 || o == 4) && h) m_valid[idx] = 0;
      end
    endcase
  endfunction

  // ---------------- stimulus ----------------
  function automatic logic [31:0] A(int tg, int idx, int w);
    return (32'(tg) << 9) | (32'(idx) << 5) | (32'(w) << 2);
  endfunction

  task automatic access(input int o, input logic [31:0] a, input logic [31:0] d, input string tag);
    logic [31:0] ev, got;
    int er, ew, r0, w0, n;
    m_access(o, a, d, ev, er, ew);
    r0 = rd_cnt; w0 = wr_cnt;
    @(negedge clk);
    req = 1'b1; op = 3'(o); addr = a; wdata = d;
    #1; n = 0;
    while (!ready && n < 1000) begin @(negedge clk); #1; n++; end
    got = rdata;
    @(posedge clk); #1;
    req = 1'b0;
    repeat (14) @(negedge clk);
    #1;
    if (o == 0) chk(got == ev, tag, "load data", got, ev);
    chk(rd_cnt - r0 == er, tag, "next-level reads", rd_cnt - r0, er);
    chk(wr_cnt - w0 == ew, tag, "next-level writes", wr_cnt - w0, ew);
    chk(int'(miss_cnt) == m_miss, tag, "miss count", miss_cnt, m_miss);
  endtask

  task automatic clear_miss();
    @(negedge clk); miss_clr = 1'b1;
    @(negedge clk); miss_clr = 1'b0; m_miss = 0;
    #1; chk(miss_cnt == '0, "R11", "cleared count", miss_cnt, 0);
  endtask

  task automatic chk_line(int la, string tag);
    chk(nl_get(la) == e_get(la), tag, "next-level line contents", nl_get(la), e_get(la));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(!mem_req, "R1", "no request after reset", mem_req, 0);
    chk(!ready, "R1", "ready low when idle", ready, 0);
    chk(miss_cnt == '0, "R1", "count zero after reset", miss_cnt, 0);

    access(0, A(1, 0, 3), 0, "R1");                 // empty cache: refill
    access(0, A(1, 0, 3), 0, "R2");                 // hit, no access
    access(3'd1, A(1, 0, 3), 32'hDEAD_0001, "R3");   // store hit
    access(0, A(1, 0, 3), 0, "R3");

    for (int w = 0; w < 8; w++) access(1, A(2, 1, w), 32'h2000_0000 + w, "R4");
    access(0, A(2, 1, 0), 0, "R4");
    access(0, A(2, 1, 7), 0, "R4");
    for (int w = 7; w >= 0; w--) access(1, A(3, 1, w), 32'h3000_0000 + w, "R6");
    chk_line(2 * 16 + 1, "R6");

    access(1, A(4, 2, 0), 32'h4000_0000, "R10");
    access(1, A(4, 2, 1), 32'h4000_0001, "R10");
    access(1, A(4, 2, 2), 32'h4000_0002, "R10");
    access(0, A(4, 2, 1), 0, "R10");
    for (int w = 3; w < 8; w++) access(1, A(4, 2, w), 32'h4000_0000 + w, "R10");

    access(1, A(5, 3, 2), 32'h5000_0002, "R5");
    access(1, A(5, 3, 6), 32'h5000_0006, "R5");
    access(0, A(1, 0, 3), 0, "R5");                 // ends partial run
    access(0, A(5, 3, 2), 0, "R5");
    access(0, A(5, 3, 0), 0, "R5");
    access(1, A(5, 3, 0), 32'h5000_0000, "R5");

    access(1, A(6, 3, 1), 32'h6000_0001, "R6");
    access(0, A(1, 0, 3), 0, "R6");                 // dirty victim then refill
    chk_line(5 * 16 + 3, "R6");

    access(2, A(1, 0, 0), 0, "R7");
    chk_line(1 * 16 + 0, "R7");
    access(0, A(1, 0, 3), 0, "R7");
    access(2, A(1, 0, 0), 0, "R7");

    access(1, A(1, 0, 5), 32'h0BAD_0005, "R8");
    access(3, A(1, 0, 0), 0, "R8");
    access(0, A(1, 0, 5), 0, "R8");

    access(1, A(1, 0, 5), 32'h600D_0005, "R9");
    access(4, A(1, 0, 0), 0, "R9");
    chk_line(1 * 16 + 0, "R9");
    access(0, A(1, 0, 5), 0, "R9");

    clear_miss();
    for (int i = 0; i < 9; i++) access(0, A(9, i, 0), 0, "R11");
    chk(miss_cnt == CNT_W'(MAXC), "R11", "saturated count", miss_cnt, MAXC);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++; n_tests++;
    $display("FAIL R12 watchdog: actual=timeout expected=completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule